// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Hub

This block holds the control/status word of every DMA channel and applies the write rules that software uses on it. Within one word, three kinds of bit live side by side: flags that a written 1 clears, enables that a write loads, and command bits that act once and are not stored. A write that sets the run bit sends a one-cycle start pulse to the data-movement engine. With that pulse goes a flag that says whether the engine must load a descriptor before it moves any data. The engine reports what happens on a channel through per-channel event inputs. Each event sets the matching flag in that channel's word.

For each channel, five interrupt causes are formed from the flags and their enables: stop, end-of-receive, request-assert, start and end. The causes are registered per cause and merged per channel into a readable interrupt register. A single interrupt line is raised whenever any bit of that register is set. An alignment register and a programmed-I/O register share the same register port.

Top module: `dma_status_irq_hub`

## Requirements
- R1: After reset every channel status reads 0x00000008 (stop flag set), and the interrupt register, alignment register and programmed-I/O register read 0, with irq low.
- R2: A write to the status word at byte offset 4·n keeps bits 3, 4, 8 and 10. It clears each of bits 0, 1, 2 and 9 where the written value holds a 1 and leaves them where it holds a 0. It loads bits 23 and 26 to 31 from the value. Every other bit, including 22, 24 and 25, reads back 0.
- R3: When bit 29 (stop-interrupt enable) is set after a status write, that write clears the stop flag (bit 3).
- R4: A status write with bit 31 (run) set clears the stop flag. In the next cycle it drives run_pulse[n] high for one cycle. fetch_first[n] is high with the pulse unless bit 30 of the written value was 1.
- R5: A status write with neither bit 31 nor bit 22 set forces the stop flag to 1. This is applied after the rules of R3 and R4.
- R6: Written bit 24 clears the compare flag (bit 10) and written bit 25 sets it. When both are written, the flag ends up set.
- R7: A high event input sets its flag for channel n: bus error bit 0, start bit 1, end bit 2, stop bit 3, request-assert bit 4, end-of-receive bit 9. An event in the same cycle as a write that would clear the flag leaves the flag set.
- R8: Bit n of the interrupt register (offset 0xF0) is (b3&b29)|(b9&b28)|(b4&b23)|b1|b2 of channel n's status. It changes one cycle after the status change that causes it.
- R9: irq is high exactly when the interrupt register is nonzero.
- R10: A status read returns the stored bits with bit 8 taken from req_pend[n]. Bit 8 is never stored.
- R11: The alignment register (0xA0) stores all 32 bits. The programmed-I/O register (0xA4) keeps only bits 31 and 0 of a write.
- R12: Reads of unmapped or misaligned offsets return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write value |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read value (combinational) |
| req_pend | input | 32 | Per-channel request-pending level from the request router |
| evt_buserr | input | 32 | Engine: bus error seen |
| evt_start | input | 32 | Engine: descriptor start |
| evt_end | input | 32 | Engine: transfer end |
| evt_stop | input | 32 | Engine: channel stopped |
| evt_ras | input | 32 | Engine: request asserted |
| evt_eor | input | 32 | Engine: end of receive |
| run_pulse | output | 32 | One-cycle start command per channel |
| fetch_first | output | 32 | With run_pulse: fetch descriptor before moving data |
| irq | output | 1 | Merged interrupt line |

## Verification
The bench drives every channel through a set of write values in turn. These cover writing all ones and all zeros, run with and without descriptor fetch, enables combined with mask-run, and compare set together with clear. A design that dropped the rule order would leave the stop flag clear on a write that has the stop enable but neither run nor mask-run. A design that decoded 24/25 in the wrong order would lose the compare flag. Engine events are raised on end and middle channels, alone and in the same cycle as a clearing write, to expose a write that wins over an event. The interrupt register is sampled one cycle after an event and again the cycle after that. A design without the register stage, or with one stage too many, fails at one of those two samples.

// File: rtl/dma_sts_pkg.sv
package dma_sts_pkg;

  localparam int STS_W = 32;

  localparam int B_BUSERR  = 0;
  localparam int B_START   = 1;
  localparam int B_END     = 2;
  localparam int B_STOP    = 3;
  localparam int B_RAS     = 4;
  localparam int B_REQ     = 8;
  localparam int B_EOR     = 9;
  localparam int B_CMP     = 10;
  localparam int B_MASKRUN = 22;
  localparam int B_RASEN   = 23;
  localparam int B_CMPCLR  = 24;
  localparam int B_CMPSET  = 25;
  localparam int B_EOREN   = 28;
  localparam int B_STOPEN  = 29;
  localparam int B_NOFETCH = 30;
  localparam int B_RUN     = 31;

  localparam logic [STS_W-1:0] KEEP_MASK = 32'h0000_071F;
  localparam logic [STS_W-1:0] W1C_MASK  = 32'h0000_0207;
  localparam logic [STS_W-1:0] LOAD_MASK = 32'hFC80_0000;
  localparam logic [STS_W-1:0] STS_RESET = 32'h0000_0008;

  typedef struct packed {
    logic stop;
    logic eor;
    logic ras;
    logic start;
    logic fin;
  } cause_t;

  typedef struct packed {
    logic buserr;
    logic start;
    logic fin;
    logic stop;
    logic ras;
    logic eor;
  } evt_t;

  // Software write applied to a stored status word.
  function automatic logic [STS_W-1:0] sts_write(input logic [STS_W-1:0] cur,
                                                 input logic [STS_W-1:0] val);
    logic [STS_W-1:0] nx;
    nx = (cur & KEEP_MASK & ~(val & W1C_MASK)) | (val & LOAD_MASK);
    if (nx[B_STOPEN]) nx[B_STOP] = 1'b0;
    if (val[B_RUN]) nx[B_STOP] = 1'b0;
    if (!val[B_RUN] && !val[B_MASKRUN]) nx[B_STOP] = 1'b1;
    if (val[B_CMPCLR]) nx[B_CMP] = 1'b0;
    if (val[B_CMPSET]) nx[B_CMP] = 1'b1;
    nx[B_REQ] = 1'b0;
    return nx;
  endfunction

  // Engine events set flags on top of whatever the write produced.
  function automatic logic [STS_W-1:0] sts_events(input logic [STS_W-1:0] cur,
                                                  input evt_t e);
    logic [STS_W-1:0] nx;
    nx = cur;
    nx[B_BUSERR] = cur[B_BUSERR] | e.buserr;
    nx[B_START]  = cur[B_START]  | e.start;
    nx[B_END]    = cur[B_END]    | e.fin;
    nx[B_STOP]   = cur[B_STOP]   | e.stop;
    nx[B_RAS]    = cur[B_RAS]    | e.ras;
    nx[B_EOR]    = cur[B_EOR]    | e.eor;
    return nx;
  endfunction

  function automatic cause_t sts_causes(input logic [STS_W-1:0] s);
    cause_t c;
    c.stop  = s[B_STOP] & s[B_STOPEN];
    c.eor   = s[B_EOR]  & s[B_EOREN];
    c.ras   = s[B_RAS]  & s[B_RASEN];
    c.start = s[B_START];
    c.fin   = s[B_END];
    return c;
  endfunction

endpackage

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_sts_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [STS_W-1:0] wr_val,
  input  evt_t             evt,
  output logic [STS_W-1:0] sts,
  output cause_t           cause,
  output logic             run_pulse,
  output logic             fetch_first
);

  logic [STS_W-1:0] sts_written;
  logic [STS_W-1:0] sts_next;

  always_comb begin
    sts_written = wr_hit ? sts_write(sts, wr_val) : sts;
    sts_next    = sts_events(sts_written, evt);
  end

  assign cause = sts_causes(sts);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts         <= STS_RESET;
      run_pulse   <= 1'b0;
      fetch_first <= 1'b0;
    end else begin
      sts         <= sts_next;
      run_pulse   <= wr_hit & wr_val[B_RUN];
      fetch_first <= wr_hit & wr_val[B_RUN] & ~wr_val[B_NOFETCH];
    end
  end

endmodule

// File: rtl/dma_irq_merge.sv
module dma_irq_merge
  import dma_sts_pkg::*;
#(
  parameter int NCH = 32
)(
  input  logic             clk,
  input  logic             rst_n,
  input  cause_t [NCH-1:0] cause,
  output logic   [NCH-1:0] int_vec,
  output logic             irq
);

  logic [NCH-1:0] stop_v, eor_v, ras_v, start_v, end_v;

  for (genvar n = 0; n < NCH; n++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stop_v[n]  <= 1'b0;
        eor_v[n]   <= 1'b0;
        ras_v[n]   <= 1'b0;
        start_v[n] <= 1'b0;
        end_v[n]   <= 1'b0;
      end else begin
        stop_v[n]  <= cause[n].stop;
        eor_v[n]   <= cause[n].eor;
        ras_v[n]   <= cause[n].ras;
        start_v[n] <= cause[n].start;
        end_v[n]   <= cause[n].fin;
      end
    end
  end

  assign int_vec = stop_v | eor_v | ras_v | start_v | end_v;
  assign irq     = |int_vec;

endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs #(
  parameter int             DW       = 32,
  parameter logic [DW-1:0]  PIO_MASK = 32'h8000_0001
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_align,
  input  logic          wr_pio,
  input  logic [DW-1:0] wr_val,
  output logic [DW-1:0] align_q,
  output logic [DW-1:0] pio_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      align_q <= '0;
      pio_q   <= '0;
    end else begin
      if (wr_align) align_q <= wr_val;
      if (wr_pio)   pio_q   <= wr_val & PIO_MASK;
    end
  end

endmodule

// File: rtl/dma_status_irq_hub.sv
module dma_status_irq_hub
  import dma_sts_pkg::*;
#(
  parameter int NCH = 32,
  parameter int AW  = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [STS_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [STS_W-1:0] rd_data,
  input  logic [NCH-1:0]   req_pend,
  input  logic [NCH-1:0]   evt_buserr,
  input  logic [NCH-1:0]   evt_start,
  input  logic [NCH-1:0]   evt_end,
  input  logic [NCH-1:0]   evt_stop,
  input  logic [NCH-1:0]   evt_ras,
  input  logic [NCH-1:0]   evt_eor,
  output logic [NCH-1:0]   run_pulse,
  output logic [NCH-1:0]   fetch_first,
  output logic             irq
);

  localparam int            CHW     = $clog2(NCH);
  localparam int            CH_END  = NCH * 4;
  localparam logic [AW-1:0] A_CHEND = AW'(CH_END);
  localparam logic [AW-1:0] A_ALIGN = AW'(8'hA0);
  localparam logic [AW-1:0] A_PIO   = AW'(8'hA4);
  localparam logic [AW-1:0] A_INT   = AW'(8'hF0);

  // Named internal events, also used by the bound checker.
  logic                  wr_in_ch;
  logic [CHW-1:0]        wr_idx;
  logic [NCH-1:0]        wr_hit;
  logic [NCH-1:0][STS_W-1:0] sts_q;
  cause_t [NCH-1:0]      chan_cause;
  logic [NCH-1:0]        cause_or;
  logic [NCH-1:0]        int_vec;
  logic [STS_W-1:0]      align_q;
  logic [STS_W-1:0]      pio_q;
  logic                  rd_in_ch;
  logic [CHW-1:0]        rd_idx;

  assign wr_in_ch = (wr_addr < A_CHEND) && (wr_addr[1:0] == 2'b00);
  assign wr_idx   = wr_addr[CHW+1:2];

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    evt_t ev;
    assign ev.buserr = evt_buserr[n];
    assign ev.start  = evt_start[n];
    assign ev.fin    = evt_end[n];
    assign ev.stop   = evt_stop[n];
    assign ev.ras    = evt_ras[n];
    assign ev.eor    = evt_eor[n];
    assign wr_hit[n] = wr_en && wr_in_ch && (wr_idx == CHW'(n));

    dma_chan_status i_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_hit      (wr_hit[n]),
      .wr_val      (wr_data),
      .evt         (ev),
      .sts         (sts_q[n]),
      .cause       (chan_cause[n]),
      .run_pulse   (run_pulse[n]),
      .fetch_first (fetch_first[n])
    );

    assign cause_or[n] = |chan_cause[n];
  end

  dma_irq_merge #(.NCH(NCH)) i_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .cause   (chan_cause),
    .int_vec (int_vec),
    .irq     (irq)
  );

  dma_cfg_regs #(.DW(STS_W), .PIO_MASK(32'h8000_0001)) i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_align (wr_en && (wr_addr == A_ALIGN)),
    .wr_pio   (wr_en && (wr_addr == A_PIO)),
    .wr_val   (wr_data),
    .align_q  (align_q),
    .pio_q    (pio_q)
  );

  assign rd_in_ch = (rd_addr < A_CHEND) && (rd_addr[1:0] == 2'b00);
  assign rd_idx   = rd_addr[CHW+1:2];

  always_comb begin
    rd_data = '0;
    if (rd_in_ch) begin
      rd_data        = sts_q[rd_idx];
      rd_data[B_REQ] = req_pend[rd_idx];
    end else if (rd_addr == A_ALIGN) begin
      rd_data = align_q;
    end else if (rd_addr == A_PIO) begin
      rd_data = pio_q;
    end else if (rd_addr == A_INT) begin
      rd_data[NCH-1:0] = int_vec;
    end
  end

endmodule

// File: rtl/dma_status_irq_hub_chk.sv
module dma_status_irq_hub_chk #(
  parameter int NCH = 32
)(
  input logic                  clk,
  input logic                  rst_n,
  input logic [NCH-1:0]        wr_hit,
  input logic [31:0]           wr_data,
  input logic [NCH-1:0][31:0]  sts_q,
  input logic [NCH-1:0]        cause_or,
  input logic [NCH-1:0]        int_vec,
  input logic                  irq,
  input logic [NCH-1:0]        run_pulse,
  input logic [31:0]           pio_q,
  input logic [NCH-1:0]        evt_stop
);

  a_r8_int_lag: assert property (@(posedge clk) disable iff (!rst_n)
    int_vec == $past(cause_or));

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|cause_or));

  a_r4_one_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(run_pulse));

  a_r11_pio_bits: assert property (@(posedge clk) disable iff (!rst_n)
    pio_q[30:1] == '0);

  for (genvar n = 0; n < NCH; n++) begin : g_p
    a_r5_forced_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit[n] && !wr_data[31] && !wr_data[22]) |=> sts_q[n][3]);

    a_r4_run_start: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit[n] && wr_data[31] && !evt_stop[n]) |=> (!sts_q[n][3] && run_pulse[n]));

    a_r6_cmp_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit[n] && wr_data[25]) |=> sts_q[n][10]);

    a_r10_req_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_q[n][8]);
  end

endmodule

bind dma_status_irq_hub dma_status_irq_hub_chk #(.NCH(NCH)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_hit    (wr_hit),
  .wr_data   (wr_data),
  .sts_q     (sts_q),
  .cause_or  (cause_or),
  .int_vec   (int_vec),
  .irq       (irq),
  .run_pulse (run_pulse),
  .pio_q     (pio_q),
  .evt_stop  (evt_stop)
);

// File: tb/test_dma_status_irq_hub.sv
module test_dma_status_irq_hub;

  localparam int NCH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [NCH-1:0] req_pend = '0;
  logic [NCH-1:0] evt_buserr = '0, evt_start = '0, evt_end = '0;
  logic [NCH-1:0] evt_stop = '0, evt_ras = '0, evt_eor = '0;
  logic [NCH-1:0] run_pulse, fetch_first;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [31:0] m_st [NCH];

  always #10 clk = ~clk;

  dma_status_irq_hub i_dma_status_irq_hub (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .req_pend(req_pend),
    .evt_buserr(evt_buserr), .evt_start(evt_start), .evt_end(evt_end),
    .evt_stop(evt_stop), .evt_ras(evt_ras), .evt_eor(evt_eor),
    .run_pulse(run_pulse), .fetch_first(fetch_first), .irq(irq)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: run did not finish, got %0d cycles, expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=%08h expected=%08h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Bench model of a status write, stated bit by bit.
  function automatic logic [31:0] m_write(input logic [31:0] o, input logic [31:0] v);
    logic [31:0] r;
    r = o & 32'h0000_0418;           // stop, request-assert, compare carry over
    r = r | (o & ~v & 32'h0000_0207); // write-one-to-clear flags
    r = r | (v & 32'hFC80_0000);      // loaded enables and commands
    if (r[29]) r[3] = 1'b0;
    if (v[31]) r[3] = 1'b0;
    if (!(v[31] || v[22])) r[3] = 1'b1;
    if (v[24]) r[10] = 1'b0;
    if (v[25]) r[10] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] m_int();
    logic [31:0] r = '0;
    for (int c = 0; c < NCH; c++)
      r[c] = (m_st[c][3] & m_st[c][29]) | (m_st[c][9] & m_st[c][28]) |
             (m_st[c][4] & m_st[c][23]) | m_st[c][1] | m_st[c][2];
    return r;
  endfunction

  task automatic pulse_evt(input int ch, input int kind);
    @(negedge clk);
    case (kind)
      0: evt_buserr[ch] = 1'b1;
      1: evt_start[ch]  = 1'b1;
      2: evt_end[ch]    = 1'b1;
      3: evt_stop[ch]   = 1'b1;
      4: evt_ras[ch]    = 1'b1;
      default: evt_eor[ch] = 1'b1;
    endcase
    @(negedge clk);
    evt_buserr = '0; evt_start = '0; evt_end = '0;
    evt_stop = '0; evt_ras = '0; evt_eor = '0;
  endtask

  function automatic int evt_bit(input int kind);
    case (kind)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 3;
      4: return 4;
      default: return 9;
    endcase
  endfunction

  initial begin
    logic [31:0] v;
    logic [31:0] pats [10];
    logic [31:0] snap [NCH];
    int evch [3];
    pats = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'hC000_0000,
             32'h2040_0000, 32'h0040_0000, 32'h0300_0000, 32'h0100_0000,
             32'h1080_0207, 32'h2C00_0000};
    evch = '{0, 9, 31};

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < NCH; c++) begin
      m_st[c] = 32'h0000_0008;
      rd(8'(c * 4), v); chk("R1 status reset", v, 32'h8);
    end
    rd(8'hF0, v); chk("R1 interrupt register reset", v, 32'h0);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);
    rd(8'hA0, v); chk("R1 alignment reset", v, 32'h0);
    rd(8'hA4, v); chk("R1 pio reset", v, 32'h0);

    // R2 R3 R4 R5 R6 R8 R9 sweep over every channel and pattern
    for (int c = 0; c < NCH; c++) begin
      for (int p = 0; p < 10; p++) begin
        wr(8'(c * 4), pats[p]);
        m_st[c] = m_write(m_st[c], pats[p]);
        rd(8'(c * 4), v); chk("R2/R3/R5/R6 status after write", v, m_st[c]);
        chk("R4 run_pulse", run_pulse, pats[p][31] ? (32'h1 << c) : 32'h0);
        chk("R4 fetch_first", fetch_first,
            (pats[p][31] && !pats[p][30]) ? (32'h1 << c) : 32'h0);
        @(negedge clk);
        rd(8'hF0, v); chk("R8 interrupt register", v, m_int());
        chk("R9 irq level", {31'b0, irq}, {31'b0, |m_int()});
      end
    end

    // quiesce: clear flags, drop enables, keep running
    for (int c = 0; c < NCH; c++) begin
      wr(8'(c * 4), 32'h0040_0207);
      m_st[c] = m_write(m_st[c], 32'h0040_0207);
    end
    @(negedge clk);
    rd(8'hF0, v); chk("R8 interrupt register quiet", v, 32'h0);

    // R7 events, plain and with enables
    for (int i = 0; i < 3; i++) begin
      for (int k = 0; k < 6; k++) begin
        pulse_evt(evch[i], k);
        m_st[evch[i]][evt_bit(k)] = 1'b1;
        rd(8'(evch[i] * 4), v); chk("R7 event sets flag", v, m_st[evch[i]]);
        @(negedge clk);
        rd(8'hF0, v); chk("R8 interrupt after event", v, m_int());
      end
      wr(8'(evch[i] * 4), 32'h3040_0207);
      m_st[evch[i]] = m_write(m_st[evch[i]], 32'h3040_0207);
      @(negedge clk);
      rd(8'hF0, v); chk("R3 stop enable clears stop flag", v, m_int());
      for (int k = 3; k < 6; k++) begin
        pulse_evt(evch[i], k);
        m_st[evch[i]][evt_bit(k)] = 1'b1;
        @(negedge clk);
        rd(8'hF0, v); chk("R8 enabled cause", v, m_int());
      end
      wr(8'(evch[i] * 4), 32'h0840_0207);
      m_st[evch[i]] = m_write(m_st[evch[i]], 32'h0840_0207);
    end
    @(negedge clk);
    rd(8'hF0, v); chk("R9 interrupt cleared", v, 32'h0);
    chk("R9 irq cleared", {31'b0, irq}, 32'h0);

    // R8 one-cycle lag of the interrupt register
    pulse_evt(17, 2);
    m_st[17][2] = 1'b1;
    rd(8'hF0, v); chk("R8 no interrupt before register stage", v, 32'h0);
    chk("R9 irq low before register stage", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rd(8'hF0, v); chk("R8 interrupt after register stage", v, 32'h1 << 17);
    chk("R9 irq high", {31'b0, irq}, 32'h1);

    // R7 event wins over a clearing write in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'd12; wr_data = 32'h8000_0207;
    evt_stop[3] = 1'b1; evt_end[3] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; evt_stop = '0; evt_end = '0;
    m_st[3] = m_write(m_st[3], 32'h8000_0207);
    m_st[3][3] = 1'b1; m_st[3][2] = 1'b1;
    rd(8'd12, v); chk("R7 event wins over write", v, m_st[3]);

    // R10 request pending read-through
    req_pend = 32'h0000_0010;
    rd(8'd16, v); chk("R10 request pending shown", v, m_st[4] | 32'h100);
    wr(8'd16, 32'h0040_0100);
    m_st[4] = m_write(m_st[4], 32'h0040_0100);
    req_pend = '0;
    rd(8'd16, v); chk("R10 request pending not stored", v, m_st[4]);

    // R11 alignment and pio registers
    wr(8'hA0, 32'hDEAD_BEEF);
    rd(8'hA0, v); chk("R11 alignment full width", v, 32'hDEAD_BEEF);
    wr(8'hA4, 32'hFFFF_FFFF);
    rd(8'hA4, v); chk("R11 pio keeps bits 31 and 0", v, 32'h8000_0001);
    wr(8'hA4, 32'h7FFF_FFFE);
    rd(8'hA4, v); chk("R11 pio drops middle bits", v, 32'h0);

    // R12 unmapped and misaligned offsets
    for (int c = 0; c < NCH; c++) begin
      rd(8'(c * 4), v); snap[c] = v;
    end
    wr(8'hB0, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    wr(8'h86, 32'hFFFF_FFFF);
    wr(8'hE0, 32'hFFFF_FFFF);
    for (int c = 0; c < NCH; c++) begin
      rd(8'(c * 4), v); chk("R12 status untouched", v, snap[c]);
    end
    rd(8'hA0, v); chk("R12 alignment untouched", v, 32'hDEAD_BEEF);
    rd(8'hA4, v); chk("R12 pio untouched", v, 32'h0);
    rd(8'hB0, v); chk("R12 unmapped read", v, 32'h0);
    rd(8'h01, v); chk("R12 misaligned read", v, 32'h0);

    summary();
    $finish;
  end

endmodule